// File: doc/BRIEF.md
# SPI Target with Frame Integrity Checking

This block is the serial front end of a register-mapped device. A controller sends fixed 32-bit frames over a four-wire SPI link. The frames use mode 0 and are sent MSB first. The block oversamples SCK, CS and SDI in its own clock domain, shifts each frame in, and judges each chip-select window in two ways. First, it checks that a 4-bit CRC over the upper 28 bits matches the CRC field in the frame. Second, it checks that exactly 32 SCK rising edges arrived while chip-select was low. A frame that passes both checks is acted on. A frame that fails either check is dropped, and the matching sticky fault flag is set.

Accepted writes are passed to a simple register port as a one-cycle strobe. Accepted reads fetch a 16-bit word from the same port. Reads of one reserved address are handled inside the block: they return the two fault flags and then clear them. During the next chip-select window, the block shifts out a 32-bit response. The response carries the flags, the outcome of the previous frame, any read data, and a CRC generated by the block. A configuration input turns off the incoming CRC comparison. The response CRC is always sent.

Top module: `spi_frame_target`

## Requirements
- R1: Frame fields, MSB first: bit 31 is the direction (1 = write, 0 = read), bits 30:24 the address, bits 23:8 the data, bits 7:4 a command nibble with no effect, and bits 3:0 the CRC. SDI is sampled on SCK rising edges.
- R2: The CRC is 4 bits, with polynomial x^4+x+1 and seed 4'hF. It is computed over frame bits 31..4, starting with bit 31. Each step shifts left, and XORs in 4'h3 when the old MSB differs from the input bit.
- R3: A window with 32 clocks whose CRC field mismatches sets the sticky CRC fault flag while checking is enabled. The frame is discarded.
- R4: A window with any SCK count other than 32 sets the sticky frame fault flag. The frame is discarded and its CRC is not judged.
- R5: While crc_dis_i is 1, a CRC mismatch is ignored. A 32-clock frame is accepted and the CRC fault flag stays unchanged.
- R6: An accepted write to any address except the status address 7'h7F gives a one-cycle reg_we_o pulse, with reg_addr_o and reg_wdata_o taken from the frame. A write to 7'h7F commits nothing.
- R7: The response shifted out in window N has these fields:
  - bit 31: CRC flag
  - bit 30: frame flag
  - bit 29: 1 if window N-1 was accepted
  - bit 28: the direction of window N-1 if it was accepted, else 0
  - bits 27:12: read data, which is 0 unless window N-1 was an accepted read
  - bit 11: 0
  - bits 10:4: the address of window N-1 if it was accepted, else 0
  - bits 3:0: the CRC of bits 31:4 per R2

  The flag bits are taken as window N opens.
- R8: An accepted read of 7'h7F returns {14'b0, frame flag, CRC flag} as read data, using the values before the read, and then clears both flags. The flags are also visible on crc_fault_o and frame_fault_o.
- R9: SDO presents response bit 31 first and advances one bit after each SCK falling edge. SDO is 0 while chip-select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, several times faster than SCK |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from controller |
| cs_ni | input | 1 | Chip-select, active low |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| crc_dis_i | input | 1 | 1 disables incoming CRC comparison |
| reg_we_o | output | 1 | Register write strobe |
| reg_addr_o | output | 7 | Register address |
| reg_wdata_o | output | 16 | Register write data |
| reg_rdata_i | input | 16 | Register read data for reg_addr_o |
| crc_fault_o | output | 1 | Sticky CRC fault flag |
| frame_fault_o | output | 1 | Sticky frame-length fault flag |

## Verification
A wrong bit count or a shifted receive register shows up as a write strobe that appears or goes missing. That difference is visible one cycle after chip-select rises. A bad CRC slice shows up as a fault flag raised on a good frame. A corrupt response register or response CRC appears in the very next window's SDO bits. A flag that fails to clear, or fails to stick, shows in the flag ports straight after the window. It shows again in bits 31:30 of the next response.

// File: rtl/spi_ft_pkg.sv
package spi_ft_pkg;
  localparam int FRAME_W = 32;
  localparam int ADDR_W  = 7;
  localparam int DATA_W  = 16;
  localparam int CMD_W   = 4;
  localparam int CRC_W   = 4;
  localparam int BODY_W  = FRAME_W - CRC_W;
  localparam logic [CRC_W-1:0] CRC_POLY = 4'h3;
  localparam logic [CRC_W-1:0] CRC_SEED = 4'hF;

  typedef struct packed {
    logic              rw;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic [CMD_W-1:0]  cmd;
    logic [CRC_W-1:0]  crc;
  } frame_t;
endpackage

// File: rtl/spi_ft_sync.sv
module spi_ft_sync #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= RST_VAL;
      else         stg_q[s] <= (s == 0) ? d_i : stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/spi_ft_crc.sv
module spi_ft_crc #(
  parameter int               DW   = 28,
  parameter int               CW   = 4,
  parameter logic [CW-1:0]    POLY = 4'h3,
  parameter logic [CW-1:0]    SEED = 4'hF
) (
  input  logic [DW-1:0] data_i,
  output logic [CW-1:0] crc_o
);
  logic [CW-1:0] c;
  logic          fb;

  always_comb begin
    c  = SEED;
    fb = 1'b0;
    for (int i = DW-1; i >= 0; i--) begin
      fb = c[CW-1] ^ data_i[i];
      c  = {c[CW-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
    crc_o = c;
  end
endmodule

// File: rtl/spi_frame_target.sv
module spi_frame_target
  import spi_ft_pkg::*;
#(
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 7'h7F
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              cs_ni,
  input  logic              sdi_i,
  output logic              sdo_o,
  input  logic              crc_dis_i,
  output logic              reg_we_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  input  logic [DATA_W-1:0] reg_rdata_i,
  output logic              crc_fault_o,
  output logic              frame_fault_o
);
  localparam int CNT_W = $clog2(FRAME_W) + 2;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;

  logic [2:0] sync_q;
  logic       cs_s, sck_s, sdi_s, cs_d, sck_d;
  logic       cs_act, frame_start, frame_end, sck_rise, sck_fall;

  spi_ft_sync #(.W(3), .STAGES(2), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sck_i, sdi_i}),
    .q_o   (sync_q)
  );
  assign {cs_s, sck_s, sdi_s} = sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_d  <= 1'b1;
      sck_d <= 1'b0;
    end else begin
      cs_d  <= cs_s;
      sck_d <= sck_s;
    end
  end

  assign cs_act      = !cs_s;
  assign frame_start = cs_d && !cs_s;
  assign frame_end   = !cs_d && cs_s;
  assign sck_rise    = cs_act && sck_s && !sck_d;
  assign sck_fall    = cs_act && !sck_s && sck_d;

  // receive path
  logic [FRAME_W-1:0] rx_sh;
  logic [CNT_W-1:0]   bit_cnt;
  frame_t             fr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_sh   <= '0;
      bit_cnt <= '0;
    end else if (frame_start) begin
      bit_cnt <= '0;
    end else if (sck_rise) begin
      rx_sh   <= {rx_sh[FRAME_W-2:0], sdi_s};
      bit_cnt <= (bit_cnt == CNT_MAX) ? bit_cnt : bit_cnt + 1'b1;
    end
  end

  assign fr = frame_t'(rx_sh);
  logic unused_cmd;
  assign unused_cmd = ^fr.cmd;

  logic [CRC_W-1:0] rx_crc;
  spi_ft_crc #(.DW(BODY_W), .CW(CRC_W), .POLY(CRC_POLY), .SEED(CRC_SEED)) u_crc_rx (
    .data_i(rx_sh[FRAME_W-1:CRC_W]),
    .crc_o (rx_crc)
  );

  logic len_ok, crc_bad, frame_ok, stat_hit, stat_clr;
  assign len_ok   = (bit_cnt == CNT_FULL);
  assign crc_bad  = (rx_crc != fr.crc);
  assign frame_ok = len_ok && (crc_dis_i || !crc_bad);
  assign stat_hit = (fr.addr == STATUS_ADDR);
  assign stat_clr = frame_end && frame_ok && !fr.rw && stat_hit;

  // sticky flags and previous-frame record
  logic              crc_flt_q, frm_flt_q, last_ok_q, last_rw_q, we_q;
  logic [ADDR_W-1:0] last_addr_q;
  logic [DATA_W-1:0] rd_data_q, stat_word;

  assign stat_word = {{(DATA_W-2){1'b0}}, frm_flt_q, crc_flt_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_flt_q   <= 1'b0;
      frm_flt_q   <= 1'b0;
      last_ok_q   <= 1'b0;
      last_rw_q   <= 1'b0;
      last_addr_q <= '0;
      rd_data_q   <= '0;
      we_q        <= 1'b0;
    end else begin
      we_q <= frame_end && frame_ok && fr.rw && !stat_hit;
      if (frame_end) begin
        if (!len_ok)                     frm_flt_q <= 1'b1;
        else if (crc_bad && !crc_dis_i) crc_flt_q <= 1'b1;
        if (stat_clr) begin
          crc_flt_q <= 1'b0;
          frm_flt_q <= 1'b0;
        end
        last_ok_q   <= frame_ok;
        last_rw_q   <= frame_ok && fr.rw;
        last_addr_q <= frame_ok ? fr.addr : '0;
        rd_data_q   <= (frame_ok && !fr.rw) ? (stat_hit ? stat_word : reg_rdata_i) : '0;
      end
    end
  end

  assign reg_we_o      = we_q;
  assign reg_addr_o    = fr.addr;
  assign reg_wdata_o   = fr.data;
  assign crc_fault_o   = crc_flt_q;
  assign frame_fault_o = frm_flt_q;

  // transmit path
  logic [BODY_W-1:0]  resp_body;
  logic [CRC_W-1:0]   tx_crc;
  logic [FRAME_W-1:0] tx_sh;

  assign resp_body = {crc_flt_q, frm_flt_q, last_ok_q, last_rw_q, rd_data_q, 1'b0, last_addr_q};

  spi_ft_crc #(.DW(BODY_W), .CW(CRC_W), .POLY(CRC_POLY), .SEED(CRC_SEED)) u_crc_tx (
    .data_i(resp_body),
    .crc_o (tx_crc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          tx_sh <= '0;
    else if (frame_start) tx_sh <= {resp_body, tx_crc};
    else if (sck_fall)    tx_sh <= {tx_sh[FRAME_W-2:0], 1'b0};
  end

  assign sdo_o = cs_act && tx_sh[FRAME_W-1];
endmodule

// File: rtl/spi_frame_target_chk.sv
module spi_frame_target_chk
  import spi_ft_pkg::*;
#(
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 7'h7F,
  parameter int                CNT_W       = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic              crc_dis_i,
  input logic              sdo_o,
  input logic              reg_we_o,
  input logic [ADDR_W-1:0] reg_addr_o,
  input logic              crc_flt_q,
  input logic              frm_flt_q,
  input logic              stat_clr,
  input logic              frame_end,
  input logic [CNT_W-1:0]  bit_cnt
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

  a_r6_we_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);

  a_r6_no_status_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> reg_addr_o != STATUS_ADDR);

  a_r4_we_needs_full_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> ($past(frame_end) && $past(bit_cnt) == CNT_FULL));

  a_r4_frame_flag_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frm_flt_q) |-> ($past(frame_end) && $past(bit_cnt) != CNT_FULL));

  a_r5_crc_flag_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(crc_flt_q) |-> !$past(crc_dis_i));

  a_r3_crc_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (crc_flt_q && !stat_clr) |=> crc_flt_q);

  a_r4_frame_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_flt_q && !stat_clr) |=> frm_flt_q);

  a_r9_sdo_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && $past(cs_ni) && $past(cs_ni, 2) && $past(cs_ni, 3)) |-> !sdo_o);
endmodule

bind spi_frame_target spi_frame_target_chk #(.STATUS_ADDR(STATUS_ADDR), .CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_ni     (cs_ni),
  .crc_dis_i (crc_dis_i),
  .sdo_o     (sdo_o),
  .reg_we_o  (reg_we_o),
  .reg_addr_o(reg_addr_o),
  .crc_flt_q (crc_flt_q),
  .frm_flt_q (frm_flt_q),
  .stat_clr  (stat_clr),
  .frame_end (frame_end),
  .bit_cnt   (bit_cnt)
);

// File: tb/spi_frame_target_tb.sv
`timescale 1ns/1ps
module spi_frame_target_tb;
  localparam int H = 6;
  localparam logic [6:0] STAT = 7'h7F;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, sdi = 1'b0, crc_dis = 1'b0;
  logic sdo, we, crc_f, frm_f;
  logic [6:0]  addr;
  logic [15:0] wdata, rdata;
  logic [15:0] mem [128];
  int we_cnt = 0;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  spi_frame_target #(.STATUS_ADDR(STAT)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .cs_ni(cs_n), .sdi_i(sdi),
    .sdo_o(sdo), .crc_dis_i(crc_dis), .reg_we_o(we), .reg_addr_o(addr),
    .reg_wdata_o(wdata), .reg_rdata_i(rdata), .crc_fault_o(crc_f),
    .frame_fault_o(frm_f)
  );

  assign rdata = mem[addr];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) mem[i] <= '0;
    end else if (we) begin
      mem[addr] <= wdata;
      we_cnt    <= we_cnt + 1;
    end
  end

  // reference model
  logic        m_crc = 0, m_frm = 0, m_ok = 0, m_rw = 0;
  logic [6:0]  m_addr = '0;
  logic [15:0] m_rd = '0;
  logic [15:0] exp_mem [128];
  int          exp_we = 0;

  function automatic logic [3:0] ref_crc(input logic [27:0] d);
    logic [3:0] c = 4'hF;
    for (int i = 27; i >= 0; i--) begin
      logic msb = c[3];
      c = c << 1;
      if (msb != d[i]) c = c ^ 4'b0011;
    end
    return c;
  endfunction

  function automatic logic [31:0] mk_frame(input logic rw, input logic [6:0] a,
      input logic [15:0] d, input logic [3:0] cmd, input logic good);
    logic [27:0] b = {rw, a, d, cmd};
    logic [3:0]  c = ref_crc(b);
    return {b, good ? c : (c ^ 4'h9)};
  endfunction

  function automatic logic [31:0] exp_resp();
    logic [27:0] b = {m_crc, m_frm, m_ok, m_rw, m_rd, 1'b0, m_addr};
    return {b, ref_crc(b)};
  endfunction

  task automatic model_update(input logic [31:0] f, input int nclk);
    logic ok = 1'b0;
    if (nclk != 32) m_frm = 1'b1;
    else if (!crc_dis && ref_crc(f[31:4]) != f[3:0]) m_crc = 1'b1;
    else ok = 1'b1;
    m_ok = ok; m_rw = ok & f[31]; m_addr = ok ? f[30:24] : '0; m_rd = '0;
    if (ok && f[31] && f[30:24] != STAT) begin
      exp_mem[f[30:24]] = f[23:8]; exp_we++;
    end else if (ok && !f[31]) begin
      if (f[30:24] == STAT) begin
        m_rd = {14'b0, m_frm, m_crc}; m_crc = 1'b0; m_frm = 1'b0;
      end else m_rd = exp_mem[f[30:24]];
    end
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [31:0] f, input int nclk, output logic [31:0] got);
    got = '0;
    @(negedge clk); cs_n = 1'b0;
    for (int k = 0; k < nclk; k++) begin
      sdi = (k < 32) ? f[31-k] : 1'b0;
      repeat (H) @(negedge clk);
      if (k < 32) got[31-k] = sdo;
      sck = 1'b1;
      repeat (H) @(negedge clk);
      sck = 1'b0;
    end
    repeat (H) @(negedge clk);
    cs_n = 1'b1; sdi = 1'b0;
    repeat (3*H) @(negedge clk);
  endtask

  task automatic run(input logic [31:0] f, input int nclk, input string tag);
    logic [31:0] exp, got;
    exp = exp_resp();
    xfer(f, nclk, got);
    if (nclk == 32) begin
      check(got === exp, {tag, " response"}, got, exp);
      check(got[3:0] == ref_crc(got[31:4]), "R2 response crc", got[3:0], ref_crc(got[31:4]));
    end
    model_update(f, nclk);
    check(we_cnt == exp_we, {tag, " R6 write count"}, we_cnt, exp_we);
    check({frm_f, crc_f} == {m_frm, m_crc}, {tag, " R8 flag ports"}, {frm_f, crc_f}, {m_frm, m_crc});
    check(sdo == 1'b0, "R9 sdo idle", sdo, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] dummy;
    void'($urandom(32'd2024));
    for (int i = 0; i < 128; i++) exp_mem[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check({sdo, we, crc_f, frm_f} == 4'b0, "reset state", {sdo, we, crc_f, frm_f}, 0);

    // R1 R6: write then read back
    run(mk_frame(1'b1, 7'h05, 16'hA5A5, 4'h3, 1'b1), 32, "R1 write");
    check(mem[5] == 16'hA5A5, "R6 committed data", mem[5], 16'hA5A5);
    run(mk_frame(1'b0, 7'h05, 16'h0000, 4'hC, 1'b1), 32, "R1 read");
    run(mk_frame(1'b0, 7'h00, 16'h0000, 4'h0, 1'b1), 32, "R7 readback");
    // R3: bad crc write dropped
    run(mk_frame(1'b1, 7'h06, 16'h1234, 4'h0, 1'b0), 32, "R3 bad crc");
    check(mem[6] == 16'h0 && crc_f, "R3 write discarded", {crc_f, mem[6]}, 32'h10000);
    // R4: short and long windows
    run(mk_frame(1'b1, 7'h07, 16'h5555, 4'h0, 1'b1), 31, "R4 short");
    run(mk_frame(1'b1, 7'h08, 16'h6666, 4'h0, 1'b1), 33, "R4 long");
    check(mem[7] == 0 && mem[8] == 0 && frm_f, "R4 writes discarded", {frm_f, mem[7]}, 32'h10000);
    // R8: status read returns and clears
    run(mk_frame(1'b0, STAT, 16'h0, 4'h0, 1'b1), 32, "R8 status read");
    check({frm_f, crc_f} == 2'b00, "R8 flags cleared", {frm_f, crc_f}, 0);
    run(mk_frame(1'b0, 7'h01, 16'h0, 4'h0, 1'b1), 32, "R8 status data");
    // R5: disabled checking
    crc_dis = 1'b1;
    run(mk_frame(1'b1, 7'h09, 16'hBEEF, 4'h0, 1'b0), 32, "R5 crc disabled");
    check(mem[9] == 16'hBEEF && !crc_f, "R5 bad crc accepted", {crc_f, mem[9]}, 32'h0BEEF);
    crc_dis = 1'b0;
    // R6: status address write commits nothing
    run(mk_frame(1'b1, STAT, 16'hFFFF, 4'h0, 1'b1), 32, "R6 status write");
    run(mk_frame(1'b0, 7'h09, 16'h0, 4'h0, 1'b1), 32, "R7 after status write");

    // random mix
    for (int n = 0; n < 40; n++) begin
      logic rw = $urandom % 2;
      logic [6:0] a = ($urandom % 5 == 0) ? STAT : 7'($urandom % 16);
      logic good = ($urandom % 8) != 0;
      int nclk = ($urandom % 10 == 0) ? (31 + 2 * ($urandom % 2)) : 32;
      crc_dis = ($urandom % 8) == 0;
      run(mk_frame(rw, a, 16'($urandom), 4'($urandom), good), nclk, "R7 random");
    end
    crc_dis = 1'b0;
    xfer(mk_frame(1'b0, 7'h00, 16'h0, 4'h0, 1'b1), 32, dummy);
    check(dummy === exp_resp(), "R7 final response", dummy, exp_resp());

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule